// File: doc/BRIEF.md
# Cascadable Segment Line Capture

This block takes one display line of segment data from a narrow parallel bus and stores it in a 240-bit data latch. All of its state changes on the falling edge of the data clock `xck`. Several copies can be chained so that together they cover a wider panel. A line pulse arms every chip. A chip then starts taking data once its enable input is low, and from that point it keeps taking data on its own. When its line is full it deselects itself and drives its enable output low for one clock period. That pulse starts the next chip in the chain.

The bus runs either 8 bits wide, giving one byte per edge, or 4 bits wide on the low pins, giving two edges per byte. Each byte is assembled before it is written. A direction input picks which end of the latch the first byte lands on. Transferring the latch to the line register and driving the panel are handled by other blocks.

Top module: `segcap_top`

## Requirements
- R1: After reset, `enOut` is 1, `captureDone` is 0 and `latchData` is all zeros. No data is captured until a line pulse has been seen, even if `enIn` is low.
- R2: With `narrowBus` = 0, each falling edge of `xck` on which the chip is selected writes `busData[7:0]` as one byte. A line holds 30 bytes.
- R3: With `narrowBus` = 1, each byte takes two selected edges. The first edge supplies bits 3:0 and the second supplies bits 7:4, both taken from `busData[3:0]`. `busData[7:4]` is ignored.
- R4: With `fillUp` = 1, bit i of the k-th byte of a line (k from 0) is stored in `latchData[8k+i]`. Latch bit 0 drives output 1.
- R5: With `fillUp` = 0, bit i of the k-th byte is stored in `latchData[239-8k-i]`. The first byte therefore covers outputs 240 down to 233, with its bit 0 on output 240.
- R6: After a line pulse, the chip selects on the first falling edge at which `enIn` is low, and it captures data on that same edge. Edges with `enIn` high before selection capture nothing. Once selected, the chip ignores `enIn`.
- R7: After the 30th byte, the chip deselects. Further edges leave `latchData` unchanged until the next line pulse, whatever `enIn` and `busData` do.
- R8: `enOut` rests at 1. It goes to 0 for exactly one `xck` period, starting at the falling edge that writes the 30th byte and ending at the next falling edge.
- R9: `captureDone` is 1 during exactly that same period and 0 at all other times.
- R10: When `linePulse` is high at a falling edge, that edge clears the byte count, the selection and the nibble phase, and returns `enOut` to 1 and `captureDone` to 0. `latchData` is not changed, and no data is captured on that edge.
- R11: A half-assembled byte in 4-bit mode is discarded by a line pulse. It never shifts the bytes of the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xck | input | 1 | Data clock; all state changes on its falling edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busData | input | 8 | Parallel segment data |
| narrowBus | input | 1 | 1 = 4-bit bus on bits 3:0, 0 = 8-bit bus |
| fillUp | input | 1 | 1 = fill from output 1 upward, 0 = from output 240 downward |
| linePulse | input | 1 | Line pulse, sampled at falling edges; rearms the chip |
| enIn | input | 1 | Chain enable from the previous chip, active low |
| enOut | output | 1 | Chain enable to the next chip, one-period low pulse |
| latchData | output | 240 | Data latch; bit j drives output j+1 |
| captureDone | output | 1 | One-period flag marking a full line |

## Verification
Every result appears one falling edge after the stimulus that causes it: a latch byte, the `enOut` low pulse, the `captureDone` flag and the effects of a line pulse. Nothing is pipelined beyond that edge. The bench therefore changes inputs on a rising edge, lets exactly one falling edge act on them, and samples on the following rising edge, half a period after the edge that caused the change. The pulse checks sample once inside the pulse and once one edge later, which shows the pulse is exactly one period wide. The latch is compared in full after the line has completed and extra edges have been applied.

// File: rtl/segcap_pkg.sv
`timescale 1ns/1ps
package segcap_pkg;
  // width of the byte slot index; covers lines up to 255 bytes
  localparam int SLOT_IDX_W = 8;
  localparam int BYTE_W     = 8;
  localparam int NIB_W      = BYTE_W / 2;

  typedef struct packed {
    logic                  byteWrite;   // write assembled byte into slot byteIdx
    logic                  nibbleLoad;  // hold low nibble of a 4-bit pair
    logic                  clearNibble; // drop any held nibble
    logic [SLOT_IDX_W-1:0] byteIdx;     // slot written by byteWrite
  } capStrobes_t;
endpackage

// File: rtl/segcap_ctrl.sv
`timescale 1ns/1ps
module segcap_ctrl
  import segcap_pkg::*;
#(
  parameter int LINE_BITS = 240
) (
  input  logic        xck,
  input  logic        rstN,
  input  logic        narrowBus,
  input  logic        linePulse,
  input  logic        enIn,
  output capStrobes_t strobes,
  output logic        enOut,
  output logic        captureDone
);
  localparam int BYTES = LINE_BITS / BYTE_W;
  localparam logic [SLOT_IDX_W-1:0] LAST_SLOT = SLOT_IDX_W'(BYTES - 1);
  localparam logic [SLOT_IDX_W-1:0] FULL_CNT  = SLOT_IDX_W'(BYTES);

  logic                  armed;     // line pulse seen, waiting for enIn low
  logic                  selected;  // capturing this line
  logic                  lineFull;  // all bytes written
  logic                  nibPhase;  // 1: next narrow word is the high nibble
  logic [SLOT_IDX_W-1:0] byteCnt;

  logic takeWord, byteWrite, nibbleLoad, lastByte;

  always_comb begin
    takeWord   = !linePulse && !lineFull && (selected || (armed && !enIn));
    byteWrite  = takeWord && (!narrowBus || nibPhase);
    nibbleLoad = takeWord && narrowBus && !nibPhase;
    lastByte   = byteWrite && (byteCnt == LAST_SLOT);
  end

  always_comb begin
    strobes.byteWrite   = byteWrite;
    strobes.nibbleLoad  = nibbleLoad;
    strobes.clearNibble = linePulse;
    strobes.byteIdx     = byteCnt;
  end

  always_ff @(negedge xck or negedge rstN) begin
    if (!rstN) begin
      armed       <= 1'b0;
      selected    <= 1'b0;
      lineFull    <= 1'b0;
      nibPhase    <= 1'b0;
      byteCnt     <= '0;
      enOut       <= 1'b1;
      captureDone <= 1'b0;
    end else if (linePulse) begin
      armed       <= 1'b1;
      selected    <= 1'b0;
      lineFull    <= 1'b0;
      nibPhase    <= 1'b0;
      byteCnt     <= '0;
      enOut       <= 1'b1;
      captureDone <= 1'b0;
    end else begin
      enOut       <= !lastByte;
      captureDone <= lastByte;
      if (takeWord) begin
        armed    <= 1'b0;
        selected <= !lastByte;
      end
      if (byteWrite) byteCnt <= byteCnt + 1'b1;
      if (lastByte)  lineFull <= 1'b1;
      if (!narrowBus)    nibPhase <= 1'b0;
      else if (takeWord) nibPhase <= !nibPhase;
    end
  end

  AST_ENOUT_SINGLE: assert property (@(negedge xck) disable iff (!rstN)
    !enOut |=> enOut);  // R8
  AST_FULL_HOLDS: assert property (@(negedge xck) disable iff (!rstN)
    (lineFull && !linePulse) |=> $stable(byteCnt));  // R7
  AST_LP_RESTORES: assert property (@(negedge xck) disable iff (!rstN)
    linePulse |=> (enOut && !captureDone && byteCnt == '0));  // R10
  AST_CNT_BOUND: assert property (@(negedge xck) disable iff (!rstN)
    byteCnt <= FULL_CNT);  // R2
endmodule

// File: rtl/segcap_datapath.sv
`timescale 1ns/1ps
module segcap_datapath
  import segcap_pkg::*;
#(
  parameter int LINE_BITS = 240
) (
  input  logic                 xck,
  input  logic                 rstN,
  input  logic [BYTE_W-1:0]    busData,
  input  logic                 narrowBus,
  input  logic                 fillUp,
  input  capStrobes_t          strobes,
  output logic [LINE_BITS-1:0] latchData
);
  localparam int BYTES = LINE_BITS / BYTE_W;

  logic [NIB_W-1:0]  heldNibble;
  logic [BYTE_W-1:0] assembled;

  always_ff @(negedge xck or negedge rstN) begin
    if (!rstN)                   heldNibble <= '0;
    else if (strobes.clearNibble) heldNibble <= '0;
    else if (strobes.nibbleLoad)  heldNibble <= busData[NIB_W-1:0];
  end

  always_comb begin
    assembled = narrowBus ? {busData[NIB_W-1:0], heldNibble} : busData;
  end

  // each latch bit has one slot/bit source per fill direction
  for (genvar j = 0; j < LINE_BITS; j++) begin : g_bit
    localparam int UP_SLOT = j / BYTE_W;
    localparam int UP_POS  = j % BYTE_W;
    localparam int DN_SLOT = (LINE_BITS - 1 - j) / BYTE_W;
    localparam int DN_POS  = (LINE_BITS - 1 - j) % BYTE_W;
    logic hitBit, newBit, bitQ;

    always_comb begin
      hitBit = fillUp ? (strobes.byteIdx == SLOT_IDX_W'(UP_SLOT))
                      : (strobes.byteIdx == SLOT_IDX_W'(DN_SLOT));
      newBit = fillUp ? assembled[UP_POS] : assembled[DN_POS];
    end

    always_ff @(negedge xck or negedge rstN) begin
      if (!rstN)                          bitQ <= 1'b0;
      else if (strobes.byteWrite && hitBit) bitQ <= newBit;
    end

    assign latchData[j] = bitQ;
  end

  AST_LATCH_QUIET: assert property (@(negedge xck) disable iff (!rstN)
    !strobes.byteWrite |=> $stable(latchData));  // R7
  AST_NIBBLE_ALTERNATE: assert property (@(negedge xck) disable iff (!rstN)
    strobes.nibbleLoad |=> !strobes.nibbleLoad);  // R3
  AST_SLOT_RANGE: assert property (@(negedge xck) disable iff (!rstN)
    strobes.byteWrite |-> (strobes.byteIdx < SLOT_IDX_W'(BYTES)));  // R2
endmodule

// File: rtl/segcap_top.sv
`timescale 1ns/1ps
module segcap_top
  import segcap_pkg::*;
#(
  parameter int LINE_BITS = 240
) (
  input  logic                 xck,
  input  logic                 rstN,
  input  logic [7:0]           busData,
  input  logic                 narrowBus,
  input  logic                 fillUp,
  input  logic                 linePulse,
  input  logic                 enIn,
  output logic                 enOut,
  output logic [LINE_BITS-1:0] latchData,
  output logic                 captureDone
);
  capStrobes_t strobes;

  segcap_ctrl #(.LINE_BITS(LINE_BITS)) u_ctrl (
    .xck        (xck),
    .rstN       (rstN),
    .narrowBus  (narrowBus),
    .linePulse  (linePulse),
    .enIn       (enIn),
    .strobes    (strobes),
    .enOut      (enOut),
    .captureDone(captureDone)
  );

  segcap_datapath #(.LINE_BITS(LINE_BITS)) u_dp (
    .xck      (xck),
    .rstN     (rstN),
    .busData  (busData),
    .narrowBus(narrowBus),
    .fillUp   (fillUp),
    .strobes  (strobes),
    .latchData(latchData)
  );
endmodule

// File: tb/sim_segcap_top.sv
`timescale 1ns/1ps
module sim_segcap_top;
  localparam int LB    = 240;
  localparam int BYTES = LB / 8;

  logic          xck = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    busData = '0;
  logic          narrowBus = 1'b0;
  logic          fillUp = 1'b1;
  logic          linePulse = 1'b0;
  logic          enIn = 1'b1;
  logic          enOut, captureDone;
  logic [LB-1:0] latchData;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 xck = ~xck;  // 250 MHz

  segcap_top #(.LINE_BITS(LB)) u0 (
    .xck(xck), .rstN(rstN), .busData(busData), .narrowBus(narrowBus),
    .fillUp(fillUp), .linePulse(linePulse), .enIn(enIn),
    .enOut(enOut), .latchData(latchData), .captureDone(captureDone)
  );

  task automatic check(string req, logic [LB-1:0] act, logic [LB-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a rising edge, let one falling edge act, return at next rising edge
  task automatic step(logic [7:0] d, logic en, logic lp);
    busData = d; enIn = en; linePulse = lp;
    @(posedge xck);
  endtask

  function automatic logic [7:0] byteVal(int seed, int k);
    return 8'(k * 37 + seed * 53 + 7);
  endfunction

  task automatic runLine(bit narrow, bit up, int seed, string extra);
    logic [LB-1:0] prior, expv;
    logic [7:0]    b;
    string         mapTag, wTag;
    mapTag = up ? "R4" : "R5";
    wTag   = narrow ? "R3" : "R2";
    narrowBus = narrow; fillUp = up;
    prior = latchData;
    step(8'h3C, 1'b1, 1'b1);
    check("R10 enOut after line pulse", LB'(enOut), LB'(1'b1));
    check("R10 captureDone after line pulse", LB'(captureDone), '0);
    check("R10 latch kept on line pulse", latchData, prior);
    step(8'hFF, 1'b1, 1'b0);
    step(8'h81, 1'b1, 1'b0);
    check("R6 no capture while enIn high", latchData, prior);
    expv = '0;
    for (int k = 0; k < BYTES; k++) begin
      b = byteVal(seed, k);
      for (int i = 0; i < 8; i++) begin
        if (up) expv[8*k + i] = b[i];
        else    expv[LB-1 - 8*k - i] = b[i];
      end
      if (k == BYTES - 1) begin
        check("R8 enOut rests high", LB'(enOut), LB'(1'b1));
        check("R9 captureDone low before full", LB'(captureDone), '0);
      end
      if (narrow) begin
        step({~b[3:0], b[3:0]}, (k == 0) ? 1'b0 : 1'b1, 1'b0);
        step({b[3:0] ^ 4'h6, b[7:4]}, 1'b1, 1'b0);
      end else begin
        step(b, (k == 0) ? 1'b0 : 1'b1, 1'b0);
      end
    end
    check("R8 enOut low after last byte", LB'(enOut), '0);
    check("R9 captureDone high after last byte", LB'(captureDone), LB'(1'b1));
    step(8'h5A, 1'b0, 1'b0);
    check("R8 enOut back high after one period", LB'(enOut), LB'(1'b1));
    check("R9 captureDone one period only", LB'(captureDone), '0);
    step(8'hC3, 1'b0, 1'b0);
    step(8'h0F, 1'b0, 1'b0);
    check($sformatf("%s %s R6 R7 %s latch contents", mapTag, wTag, extra), latchData, expv);
  endtask

  initial begin
    repeat (3) @(posedge xck);
    rstN = 1'b1;
    @(posedge xck);
    check("R1 enOut reset", LB'(enOut), LB'(1'b1));
    check("R1 captureDone reset", LB'(captureDone), '0);
    check("R1 latch reset", latchData, '0);
    for (int n = 0; n < 4; n++) step(8'hAA, 1'b0, 1'b0);
    check("R1 no capture before line pulse", latchData, '0);
    check("R1 enOut before line pulse", LB'(enOut), LB'(1'b1));

    for (int w = 0; w < 2; w++)
      for (int d = 0; d < 2; d++)
        runLine(w[0], d[0], w * 2 + d + 1, "");

    // R11: half byte left behind, then line pulse, then a full narrow line
    narrowBus = 1'b1; fillUp = 1'b1;
    step(8'h00, 1'b1, 1'b1);
    step(8'h05, 1'b0, 1'b0);
    runLine(1'b1, 1'b1, 9, "R11");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule